// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

This block gathers 64 level-sensitive interrupt request lines and decides, every cycle, which one the processor should service. A source counts as active when it is requesting (through its input line or through a software force bit), has been enabled, and is not masked. Among the active sources the one with the largest programmed priority level wins. On equal levels the higher-numbered source wins. The block presents the winner's level and an interrupt vector to the processor.

Software reaches the controller through a simple 32-bit register bus with an 8-bit byte offset. Each source has a one-byte priority register. Writing a nonzero byte to that register both sets the level and enables the source. Writing zero disables it. The 64-bit request, mask and force words are each reached as two 32-bit halves. An acknowledge register returns the current vector.

The vector is the winning index plus 64, or the spurious code 24 when no source is active. The selection path is purely combinational from the registered state. A write to an offset that is not a writable register raises a one-cycle error pulse.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Each request input is captured into its pending bit on every clock edge. The bit is 1 while the input is high and 0 while it is low. Pending bits 63..32 read at offset 0x00 and bits 31..0 read at offset 0x04.
- R2: Source n is active exactly when (pending[n] OR force[n]) AND enable[n] AND NOT mask[n].
- R3: The winner is an active source whose level is the largest among all active sources.
- R4: When several active sources share the largest level, the one with the highest index wins.
- R5: `irq_vector` equals the winner index plus 64, and `irq_level` equals the winner's level. With no active source, `irq_vector` is 24 and `irq_level` is 0.
- R6: A write to offset 0x40+n sets the level of source n to write-data bits 2..0. The same write enables the source if write-data bits 7..0 are nonzero and disables it if they are zero. A read of 0x40+n returns the level in bits 2..0, with all other bits 0.
- R7: A read of offset 0xE0 returns the current `irq_vector` in bits 7..0, with all other bits 0.
- R8: Mask bits 63..32 are written and read at 0x08, and bits 31..0 at 0x0C. Force bits 63..32 are written and read at 0x10, and bits 31..0 at 0x14. Writing one half leaves the other half unchanged.
- R9: Writes to offsets 0x00 and 0x04 do not change the pending bits and raise no error.
- R10: After reset the mask is all ones, and the force bits, enables and levels are all zero. `irq_vector` is 24 and `irq_level` is 0.
- R11: A write to any offset other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 or 0x40..0x7F sets `bad_write` high for the single following cycle. Legal writes leave it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 64 | Level-sensitive request lines, one per source |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset within the 0x100-byte window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_level | output | 3 | Priority level of the winning source |
| irq_vector | output | 8 | Winner index plus 64, or 24 when idle |
| bad_write | output | 1 | One-cycle pulse after a write to an illegal offset |

## Verification
The selection path is driven with sparse random combinations of request lines, force bits, masks and per-source levels. Random stimulus exposes errors in the active-source formula and in the level comparison. Directed cases place two equal-level sources far apart, to show which way ties break. They also make a lower-numbered source outrank a higher one by level, and enable a source with a nonzero byte whose level is zero. Together these separate a reversed tie rule, a priority-encoder-only selection and a gating error in the enable path. Half-word writes to the mask and force registers, writes to the pending words and writes to an illegal offset check that register updates stay where they belong. The error pulse is checked to last exactly one cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [3:0] {
    RK_PEND_HI,
    RK_PEND_LO,
    RK_MASK_HI,
    RK_MASK_LO,
    RK_FORCE_HI,
    RK_FORCE_LO,
    RK_LEVEL,
    RK_ACK,
    RK_NONE
  } reg_kind_e;

  // Map a byte offset onto the register it selects.
  function automatic reg_kind_e decode_off(input logic [7:0] off);
    if (off[7:6] == 2'b01) return RK_LEVEL;
    case (off)
      8'h00:   return RK_PEND_HI;
      8'h04:   return RK_PEND_LO;
      8'h08:   return RK_MASK_HI;
      8'h0C:   return RK_MASK_LO;
      8'h10:   return RK_FORCE_HI;
      8'h14:   return RK_FORCE_LO;
      8'hE0:   return RK_ACK;
      default: return RK_NONE;
    endcase
  endfunction

  // Registers that accept a write without raising an error.
  function automatic logic write_legal(input reg_kind_e k);
    return (k != RK_NONE) && (k != RK_ACK);
  endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int LVLW = 3,
  parameter int BUSW = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSRC-1:0]            irq_req,
  input  logic                       bus_sel,
  input  logic                       bus_wr,
  input  logic [7:0]                 bus_addr,
  input  logic [BUSW-1:0]            bus_wdata,
  output logic [NSRC-1:0]            pend,
  output logic [NSRC-1:0]            mask,
  output logic [NSRC-1:0]            frc,
  output logic [NSRC-1:0]            en,
  output logic [NSRC-1:0][LVLW-1:0]  lvl,
  output logic                       bad_write
);
  localparam int HALF = NSRC / 2;
  localparam int IDXW = $clog2(NSRC);

  reg_kind_e       kind;
  logic            wr_en;
  logic            wr_legal;
  logic [IDXW-1:0] idx;

  assign kind     = decode_off(bus_addr);
  assign wr_en    = bus_sel && bus_wr;
  assign wr_legal = write_legal(kind);
  assign idx      = bus_addr[IDXW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= '0;
      mask      <= '1;
      frc       <= '0;
      en        <= '0;
      lvl       <= '0;
      bad_write <= 1'b0;
    end else begin
      pend      <= irq_req;
      bad_write <= wr_en && !wr_legal;
      if (wr_en) begin
        case (kind)
          RK_MASK_HI:  mask[NSRC-1:HALF] <= bus_wdata[HALF-1:0];
          RK_MASK_LO:  mask[HALF-1:0]    <= bus_wdata[HALF-1:0];
          RK_FORCE_HI: frc[NSRC-1:HALF]  <= bus_wdata[HALF-1:0];
          RK_FORCE_LO: frc[HALF-1:0]     <= bus_wdata[HALF-1:0];
          RK_LEVEL: begin
            lvl[idx] <= bus_wdata[LVLW-1:0];
            en[idx]  <= |bus_wdata[7:0];
          end
          default: ;
        endcase
      end
    end
  end

  // R1
  pend_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pend == $past(irq_req));

  // R6
  lvl_zero_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == RK_LEVEL && bus_wdata[7:0] == 8'h00) |=> !en[$past(idx)]);

  // R8
  mask_half_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == RK_MASK_HI) |=> $stable(mask[HALF-1:0]));

  // R11
  bad_write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_legal) |=> bad_write);

endmodule

// File: rtl/irqc_arb.sv
module irqc_arb #(
  parameter int NSRC = 64,
  parameter int LVLW = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSRC-1:0]            active,
  input  logic [NSRC-1:0][LVLW-1:0]  lvl,
  output logic                       win_valid,
  output logic [$clog2(NSRC)-1:0]    win_idx,
  output logic [LVLW-1:0]            win_lvl
);
  localparam int IDXW = $clog2(NSRC);

  // Ascending scan with >= so a later (higher) index takes equal levels.
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (active[i] && lvl[i] >= win_lvl) begin
        win_valid = 1'b1;
        win_idx   = IDXW'(i);
        win_lvl   = lvl[i];
      end
    end
  end

  // R2
  winner_is_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> active[win_idx]);

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irqc_pkg::*;
#(
  parameter int NSRC     = 64,
  parameter int LVLW     = 3,
  parameter int BUSW     = 32,
  parameter int VECW     = 8,
  parameter int VEC_BASE = 64,
  parameter int VEC_SPUR = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  irq_req,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [7:0]       bus_addr,
  input  logic [BUSW-1:0]  bus_wdata,
  output logic [BUSW-1:0]  bus_rdata,
  output logic [LVLW-1:0]  irq_level,
  output logic [VECW-1:0]  irq_vector,
  output logic             bad_write
);
  localparam int HALF = NSRC / 2;
  localparam int IDXW = $clog2(NSRC);

  logic [NSRC-1:0]           pend, mask, frc, en, active;
  logic [NSRC-1:0][LVLW-1:0] lvl;
  logic                      win_valid;
  logic [IDXW-1:0]           win_idx;
  logic [LVLW-1:0]           win_lvl;
  reg_kind_e                 rd_kind;

  irqc_regs #(.NSRC(NSRC), .LVLW(LVLW), .BUSW(BUSW)) u_regs (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .pend(pend), .mask(mask), .frc(frc), .en(en), .lvl(lvl), .bad_write(bad_write)
  );

  assign active = (pend | frc) & en & ~mask;

  irqc_arb #(.NSRC(NSRC), .LVLW(LVLW)) u_arb (
    .clk(clk), .rst_n(rst_n), .active(active), .lvl(lvl),
    .win_valid(win_valid), .win_idx(win_idx), .win_lvl(win_lvl)
  );

  assign irq_vector = win_valid ? VECW'(VEC_BASE + int'(win_idx)) : VECW'(VEC_SPUR);
  assign irq_level  = win_valid ? win_lvl : '0;

  assign rd_kind = decode_off(bus_addr);

  always_comb begin
    bus_rdata = '0;
    case (rd_kind)
      RK_PEND_HI:  bus_rdata = pend[NSRC-1:HALF];
      RK_PEND_LO:  bus_rdata = pend[HALF-1:0];
      RK_MASK_HI:  bus_rdata = mask[NSRC-1:HALF];
      RK_MASK_LO:  bus_rdata = mask[HALF-1:0];
      RK_FORCE_HI: bus_rdata = frc[NSRC-1:HALF];
      RK_FORCE_LO: bus_rdata = frc[HALF-1:0];
      RK_LEVEL:    bus_rdata = BUSW'(lvl[bus_addr[IDXW-1:0]]);
      RK_ACK:      bus_rdata = BUSW'(irq_vector);
      default:     bus_rdata = '0;
    endcase
  end

  // R5
  idle_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|active) |-> (irq_vector == VECW'(VEC_SPUR) && irq_level == '0));

endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_req = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq_level;
  logic [7:0]  irq_vector;
  logic        bad_write;

  int total = 0, bad = 0;
  bit done = 0;

  // bench-side model of programmed state
  logic [63:0] pend_m = '0, mask_m = '1, frc_m = '0, en_m = '0;
  logic [2:0]  lvl_m [64];

  irq_prio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_level(irq_level), .irq_vector(irq_vector),
    .bad_write(bad_write)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Highest index scanned first; a lower index only takes over on a strictly larger level.
  function automatic void expect_win(output logic [7:0] vec, output logic [2:0] lv);
    logic [63:0] act;
    int best;
    act  = (pend_m | frc_m) & en_m & ~mask_m;
    best = -1;
    lv   = 3'd0;
    for (int i = 63; i >= 0; i--)
      if (act[i] && (best < 0 || lvl_m[i] > lv)) begin
        best = i;
        lv   = lvl_m[i];
      end
    vec = (best < 0) ? 8'd24 : 8'(best + 64);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    case (a)
      8'h08: mask_m[63:32] = d;
      8'h0C: mask_m[31:0]  = d;
      8'h10: frc_m[63:32]  = d;
      8'h14: frc_m[31:0]   = d;
      default:
        if (a[7:6] == 2'b01) begin
          lvl_m[a[5:0]] = d[2:0];
          en_m[a[5:0]]  = (d[7:0] != 0);
        end
    endcase
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic drive_irq(input logic [63:0] v);
    @(negedge clk);
    irq_req = v;
    @(negedge clk);
    pend_m = v;
  endtask

  task automatic check_sel(input string tag);
    logic [7:0]  ev;
    logic [2:0]  el;
    logic [31:0] d;
    expect_win(ev, el);
    chk({tag, " R5 vector"}, irq_vector, ev);
    chk({tag, " R5 level"}, irq_level, el);
    rd(8'hE0, d);
    chk({tag, " R7 ack read"}, d, {24'd0, ev});
  endtask

  function automatic logic [63:0] sparse();
    return {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) lvl_m[i] = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R10 reset state
    chk("R10 vector after reset", irq_vector, 8'd24);
    chk("R10 level after reset", irq_level, 3'd0);
    rd(8'h08, d); chk("R10 mask hi all ones", d, 32'hFFFF_FFFF);
    rd(8'h0C, d); chk("R10 mask lo all ones", d, 32'hFFFF_FFFF);
    rd(8'h10, d); chk("R10 force hi zero", d, 0);
    rd(8'h47, d); chk("R10 level reg zero", d, 0);

    // R1 pending capture and readback
    drive_irq(64'h8000_0001_0000_0020);
    rd(8'h00, d); chk("R1 pending hi", d, 32'h8000_0001);
    rd(8'h04, d); chk("R1 pending lo", d, 32'h0000_0020);
    check_sel("R2 masked sources idle");

    // R8 half writes
    wr(8'h0C, 32'h0000_0000);
    rd(8'h08, d); chk("R8 mask hi kept", d, 32'hFFFF_FFFF);
    wr(8'h08, 32'h0000_0000);
    rd(8'h0C, d); chk("R8 mask lo kept", d, 0);
    check_sel("R2 unmasked but disabled");

    // R4 tie: sources 5 and 40 at level 3
    wr(8'h45, 32'h3); wr(8'h68, 32'h3);
    drive_irq(64'h0000_0100_0000_0020);
    check_sel("R4 tie");
    chk("R4 tie winner 40", irq_vector, 8'd104);
    wr(8'h08, 32'h0000_0100);
    check_sel("R2 mask drops 40");
    chk("R2 winner 5", irq_vector, 8'd69);
    wr(8'h08, 32'h0);

    // R3 lower index with higher level beats higher index
    wr(8'h45, 32'h6);
    check_sel("R3 higher level");
    chk("R3 winner 5", irq_vector, 8'd69);
    chk("R3 level 6", irq_level, 3'd6);

    // R6 nonzero byte with level bits zero enables at level 0; readback
    drive_irq(64'h0);
    wr(8'h7F, 32'h0000_0008);
    wr(8'h14, 32'h0);
    wr(8'h10, 32'h8000_0000);
    check_sel("R6 level0 enabled");
    chk("R6 source 63 at level 0", irq_vector, 8'd127);
    rd(8'h7F, d); chk("R6 level readback", d, 0);
    rd(8'h45, d); chk("R6 level readback 5", d, 32'h6);
    wr(8'h7F, 32'h0);
    check_sel("R6 zero write disables");
    chk("R6 disabled idle", irq_vector, 8'd24);

    // R9 pending writes ignored
    drive_irq(64'h0000_0002_0000_0000);
    wr(8'h00, 32'hFFFF_FFFF);
    chk("R9 no error", bad_write, 1'b0);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R9 pending hi kept", d, 32'h2);
    rd(8'h04, d); chk("R9 pending lo kept", d, 0);

    // R11 illegal write pulses once
    wr(8'hE0, 32'h1);
    chk("R11 bad_write high", bad_write, 1'b1);
    @(negedge clk);
    chk("R11 bad_write one cycle", bad_write, 1'b0);
    wr(8'h18, 32'h1);
    chk("R11 bad_write at 0x18", bad_write, 1'b1);
    wr(8'h40, 32'h1);
    chk("R11 legal write no error", bad_write, 1'b0);

    // random mix
    for (int n = 0; n < 300; n++) begin
      int op;
      op = $urandom % 4;
      case (op)
        0: wr(8'h40 + 8'($urandom % 64), ($urandom % 3 == 0) ? 32'h0 : 32'($urandom % 16));
        1: wr(($urandom % 2) ? 8'h08 : 8'h0C, sparse() >> 32);
        2: wr(($urandom % 2) ? 8'h10 : 8'h14, sparse() >> 32);
        default: drive_irq(~sparse());
      endcase
      check_sel("R3 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule